// File: doc/BRIEF.md
# Host-Driven Remote DMA Channel

This block moves data between a host data port and a local buffer memory under direct host control. Software loads a start address and a byte count through a small 8-bit register window. It then writes a 3-bit command that starts a read from local memory toward the host, starts a write from the host into local memory, or stops whatever transfer is running. Each data beat steps the current address and lowers the remaining count. When the count is used up and the last beat has been handed over, a sticky completion flag rises. An enable bit can route that flag to an interrupt line.

The host side carries data in two valid/ready streams. Bytes from the host enter on the inbound stream, and bytes toward the host leave on the outbound stream. A beat transfers on a clock edge where valid and ready are both high. On the outbound stream, once `m_valid` is high it stays high and `m_data` holds steady until `m_ready` accepts the beat. Only an abort may withdraw it. On the inbound stream, `s_ready` depends only on engine state, so the host may wait for it before raising `s_valid`. The memory side is a 16-bit word port with byte enables. A write takes effect in the cycle it is requested, and read data returns one cycle after `mem_re`.

Top module: `rdma_channel`

## Requirements
- R1: Register offset 4 takes a command in write bits [2:0]. 001 starts a memory-to-host read and 010 starts a host-to-memory write. 000 and 011 are ignored. A 001 or 010 that arrives while a transfer is busy is also ignored. Reading offset 4 (or 6) returns bit0 = done and bit1 = busy.
- R2: Any command with bit 2 set stops a running transfer. The clock edge that takes the command clears busy and drops any pending outbound beat. It does not set done. The current address and remaining count keep the values they had reached.
- R3: Config bit0 (offset 5) selects the mode; when it is 0 the engine is in byte mode. In byte mode each beat moves one byte, adds 1 to the address and subtracts 1 from the count. The byte travels on data bits [7:0], and outbound bits [15:8] are zero.
- R4: Config bit0 = 1 selects word mode. In word mode each beat moves two bytes, adds 2 to the address and subtracts 2 from the count. When one byte is left, the final beat moves that single byte and steps by 1.
- R5: Config bit1 sets the byte order of word mode. With bit1 = 0, the lower-addressed byte sits on host bits [7:0]. With bit1 = 1, it sits on bits [15:8]. A lone final byte uses the lane of the lower-addressed byte, and the other half of the host data is ignored on input and zero on output. In memory, the even-address byte is on lane [7:0].
- R6: Done sets when busy, the count is zero and no beat is in flight or waiting for the host. A command given with a zero count completes without any memory access.
- R7: Done stays set until the host writes offset 6 with bit0 = 1. If the engine sets done in the same cycle as a clear, done ends up set.
- R8: `irq` is high exactly when done is set and config bit2 is 1.
- R9: Writes to offsets 0/1 load the low and high bytes of the start address. Reads from the same offsets return the current address. The current address is copied from the start address only when a read or write command is accepted.
- R10: Writes to offsets 2/3 load the low and high count bytes, and reads return the remaining count. Count writes are ignored while busy. `s_ready` is high only during a busy write with count left. A pending outbound beat holds its data until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset for read and write |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| s_valid | input | 1 | Inbound host beat valid |
| s_ready | output | 1 | Inbound host beat accepted |
| s_data | input | 16 | Inbound host data |
| m_valid | output | 1 | Outbound host beat valid |
| m_ready | input | 1 | Host accepts outbound beat |
| m_data | output | 16 | Outbound host data |
| mem_we | output | 1 | Local memory write |
| mem_re | output | 1 | Local memory read request |
| mem_addr | output | AW-1 | Local memory word address |
| mem_be | output | 2 | Byte enables for the access |
| mem_wdata | output | 16 | Local memory write data |
| mem_rdata | input | 16 | Local memory read data, one cycle after mem_re |
| irq | output | 1 | Completion interrupt |

## Verification
The engine can set its completion flag in the same cycle that the host writes the clear bit. The bench provokes this by starting a transfer with a zero count on one edge and writing the clear on the very next edge. The flag must then read as set, and a second clear must drop it. Abort is also driven while an outbound beat sits unaccepted. The bench then judges the withdrawn beat, the frozen address and the remaining count at the register window.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int BYTE_W = 8;
  localparam int PORT_W = 16;

  localparam logic [2:0] OFS_ADDR_LO = 3'd0;
  localparam logic [2:0] OFS_ADDR_HI = 3'd1;
  localparam logic [2:0] OFS_CNT_LO  = 3'd2;
  localparam logic [2:0] OFS_CNT_HI  = 3'd3;
  localparam logic [2:0] OFS_CMD     = 3'd4;
  localparam logic [2:0] OFS_CFG     = 3'd5;
  localparam logic [2:0] OFS_CLR     = 3'd6;

  typedef struct packed {
    logic go_rd;
    logic go_wr;
    logic abort;
  } cmd_t;
endpackage

// File: rtl/rdma_cmd_decode.sv
module rdma_cmd_decode
  import rdma_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [2:0] code,
  input  logic       busy,
  output cmd_t       cmd
);
  always_comb begin
    cmd = '0;
    if (cmd_wr) begin
      if (code[2]) begin
        cmd.abort = 1'b1;
      end else if (!busy) begin
        case (code[1:0])
          2'b01:   cmd.go_rd = 1'b1;
          2'b10:   cmd.go_wr = 1'b1;
          default: cmd = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/rdma_addr_cnt.sv
module rdma_addr_cnt
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     start_addr,
  input  logic              adv,
  input  logic              word_mode,
  input  logic              cnt_we_lo,
  input  logic              cnt_we_hi,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [AW-1:0]     cur_addr,
  output logic [CW-1:0]     cnt,
  output logic              wide
);
  localparam int HW = CW - BYTE_W;

  assign wide = word_mode && (cnt > CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
    end else if (load) begin
      cur_addr <= start_addr;
    end else if (adv) begin
      cur_addr <= cur_addr + (wide ? AW'(2) : AW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= cnt - (wide ? CW'(2) : CW'(1));
    end else begin
      if (cnt_we_lo) cnt[BYTE_W-1:0] <= wbyte;
      if (cnt_we_hi) cnt[CW-1:BYTE_W] <= wbyte[HW-1:0];
    end
  end
endmodule

// File: rtl/rdma_wr_pack.sv
module rdma_wr_pack
  import rdma_pkg::*;
(
  input  logic              word_mode,
  input  logic              big_end,
  input  logic              wide,
  input  logic              lane,
  input  logic [PORT_W-1:0] host_in,
  output logic [PORT_W-1:0] to_mem,
  output logic [1:0]        be
);
  logic [BYTE_W-1:0] lone;

  always_comb begin
    lone = (word_mode && big_end) ? host_in[PORT_W-1:BYTE_W] : host_in[BYTE_W-1:0];
    if (wide) begin
      be     = 2'b11;
      to_mem = big_end ? {host_in[BYTE_W-1:0], host_in[PORT_W-1:BYTE_W]} : host_in;
    end else begin
      be     = lane ? 2'b10 : 2'b01;
      to_mem = {lone, lone};
    end
  end
endmodule

// File: rtl/rdma_rd_stage.sv
module rdma_rd_stage
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              issue,
  input  logic              wide,
  input  logic              lane,
  input  logic              word_mode,
  input  logic              big_end,
  input  logic [PORT_W-1:0] mem_rdata,
  input  logic              m_ready,
  output logic              inflight,
  output logic              m_valid,
  output logic [PORT_W-1:0] m_data
);
  logic              wide_q, lane_q;
  logic [BYTE_W-1:0] pick;
  logic [PORT_W-1:0] shaped;

  always_comb begin
    pick = lane_q ? mem_rdata[PORT_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0];
    if (wide_q) begin
      shaped = big_end ? {mem_rdata[BYTE_W-1:0], mem_rdata[PORT_W-1:BYTE_W]} : mem_rdata;
    end else if (word_mode && big_end) begin
      shaped = {pick, {BYTE_W{1'b0}}};
    end else begin
      shaped = {{BYTE_W{1'b0}}, pick};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= 1'b0;
      m_valid  <= 1'b0;
      m_data   <= '0;
      wide_q   <= 1'b0;
      lane_q   <= 1'b0;
    end else if (flush) begin
      inflight <= 1'b0;
      m_valid  <= 1'b0;
    end else begin
      inflight <= issue;
      if (issue) begin
        wide_q <= wide;
        lane_q <= lane;
      end
      if (inflight) begin
        m_valid <= 1'b1;
        m_data  <= shaped;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdma_channel.sv
module rdma_channel
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [15:0]       s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [15:0]       m_data,
  output logic              mem_we,
  output logic              mem_re,
  output logic [AW-2:0]     mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              irq
);
  localparam int AHW = AW - BYTE_W;

  cmd_t          cmd;
  logic          busy_q, dir_wr_q, done_q;
  logic [2:0]    cfg_q;
  logic [AW-1:0] start_q, cur_addr;
  logic [CW-1:0] cnt;
  logic          wide, inflight, finish, adv, wr_fire, rd_issue, clr_done;
  logic          word_mode, big_end, abort_now;

  assign word_mode = cfg_q[0];
  assign big_end   = cfg_q[1];
  assign abort_now = cmd.abort;

  rdma_cmd_decode u_dec (
    .cmd_wr (cfg_we && cfg_addr == OFS_CMD),
    .code   (cfg_wdata[2:0]),
    .busy   (busy_q),
    .cmd    (cmd)
  );

  rdma_addr_cnt #(.AW(AW), .CW(CW)) u_ac (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cmd.go_rd | cmd.go_wr),
    .start_addr (start_q),
    .adv        (adv),
    .word_mode  (word_mode),
    .cnt_we_lo  (cfg_we && cfg_addr == OFS_CNT_LO && !busy_q),
    .cnt_we_hi  (cfg_we && cfg_addr == OFS_CNT_HI && !busy_q),
    .wbyte      (cfg_wdata),
    .cur_addr   (cur_addr),
    .cnt        (cnt),
    .wide       (wide)
  );

  rdma_wr_pack u_pack (
    .word_mode (word_mode),
    .big_end   (big_end),
    .wide      (wide),
    .lane      (cur_addr[0]),
    .host_in   (s_data),
    .to_mem    (mem_wdata),
    .be        (mem_be)
  );

  rdma_rd_stage u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (abort_now),
    .issue     (rd_issue),
    .wide      (wide),
    .lane      (cur_addr[0]),
    .word_mode (word_mode),
    .big_end   (big_end),
    .mem_rdata (mem_rdata),
    .m_ready   (m_ready),
    .inflight  (inflight),
    .m_valid   (m_valid),
    .m_data    (m_data)
  );

  assign s_ready  = busy_q && dir_wr_q && (cnt != '0);
  assign wr_fire  = s_valid && s_ready;
  assign rd_issue = busy_q && !dir_wr_q && (cnt != '0) && !inflight && !m_valid && !abort_now;
  assign adv      = wr_fire || rd_issue;
  assign finish   = busy_q && (cnt == '0) && !inflight && !m_valid && !abort_now;
  assign clr_done = cfg_we && cfg_addr == OFS_CLR && cfg_wdata[0];

  assign mem_we   = wr_fire;
  assign mem_re   = rd_issue;
  assign mem_addr = cur_addr[AW-1:1];
  assign irq      = done_q && cfg_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      dir_wr_q <= 1'b0;
    end else if (abort_now) begin
      busy_q   <= 1'b0;
    end else if (cmd.go_rd || cmd.go_wr) begin
      busy_q   <= 1'b1;
      dir_wr_q <= cmd.go_wr;
    end else if (finish) begin
      busy_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (finish) begin
      done_q <= 1'b1;
    end else if (clr_done) begin
      done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cfg_q   <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == OFS_ADDR_LO) start_q[BYTE_W-1:0] <= cfg_wdata;
      if (cfg_addr == OFS_ADDR_HI) start_q[AW-1:BYTE_W] <= cfg_wdata[AHW-1:0];
      if (cfg_addr == OFS_CFG)     cfg_q <= cfg_wdata[2:0];
    end
  end

  always_comb begin
    case (cfg_addr)
      OFS_ADDR_LO:     cfg_rdata = cur_addr[BYTE_W-1:0];
      OFS_ADDR_HI:     cfg_rdata = 8'(cur_addr[AW-1:BYTE_W]);
      OFS_CNT_LO:      cfg_rdata = cnt[BYTE_W-1:0];
      OFS_CNT_HI:      cfg_rdata = 8'(cnt[CW-1:BYTE_W]);
      OFS_CMD, OFS_CLR: cfg_rdata = {6'd0, busy_q, done_q};
      OFS_CFG:         cfg_rdata = {5'd0, cfg_q};
      default:         cfg_rdata = 8'd0;
    endcase
  end
endmodule

// File: rtl/rdma_channel_chk.sv
module rdma_channel_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_addr,
  input logic [7:0]    cfg_wdata,
  input logic          busy,
  input logic          done,
  input logic          abort_now,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [15:0]   m_data,
  input logic          mem_we,
  input logic          mem_re,
  input logic [1:0]    mem_be,
  input logic [AW-1:0] cur_addr,
  input logic          irq
);
  logic clr_wr;
  assign clr_wr = cfg_we && cfg_addr == 3'd6 && cfg_wdata[0];

  assert_abort_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now |=> !busy && !m_valid);

  assert_abort_holds_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now && !mem_we && !mem_re |=> $stable(cur_addr));

  assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) && mem_be == 2'b11 |=> cur_addr == $past(cur_addr) + AW'(2));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr_wr |=> done);

  assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  assert_hold_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready && !abort_now |=> m_valid && $stable(m_data));

  assert_sready_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy);

  assert_one_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

bind rdma_channel rdma_channel_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .busy      (busy_q),
  .done      (done_q),
  .abort_now (abort_now),
  .s_ready   (s_ready),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_be    (mem_be),
  .cur_addr  (cur_addr),
  .irq       (irq)
);

// File: tb/rdma_channel_bench.sv
module rdma_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [15:0] m_data;
  logic        mem_we, mem_re;
  logic [14:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int mem_acc = 0;
  bit bp_hold = 1'b0;
  bit bp_toggle = 1'b0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];
  logic [15:0] mem [256];

  always #10 clk = ~clk;

  rdma_channel u_rdma_channel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_be[0]) mem[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) mem[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
    end
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_we || mem_re) mem_acc <= mem_acc + 1;
  end

  function automatic logic [7:0] mbyte(input int a);
    return a[0] ? mem[a >> 1][15:8] : mem[a >> 1][7:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // Scoreboard monitor: decides ready, then judges the beat the next edge takes.
  initial begin
    forever begin
      @(negedge clk);
      if (bp_hold) m_ready = 1'b0;
      else if (bp_toggle) m_ready = ~m_ready;
      else m_ready = 1'b1;
      if (rst_n && m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected outbound beat", {16'd0, m_data}, 32'd0);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(m_data == e, "R3/R4/R5 outbound data", {16'd0, m_data}, {16'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic cfg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic prog(input logic [15:0] start, input logic [15:0] count, input logic [2:0] cfg);
    cfg_wr(3'd0, start[7:0]);
    cfg_wr(3'd1, start[15:8]);
    cfg_wr(3'd2, count[7:0]);
    cfg_wr(3'd3, count[15:8]);
    cfg_wr(3'd5, {5'd0, cfg});
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk);
    s_valid = 1'b1; s_data = d;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1 s_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    logic [7:0] v;
    v = '0;
    for (int i = 0; i < 200; i++) begin
      rd(3'd4, v);
      if (v[0]) break;
    end
    check(v[1:0] == 2'b01, tag, {24'd0, v}, 32'h1);
  endtask

  task automatic rd_addr(output logic [15:0] a);
    logic [7:0] lo, hi;
    rd(3'd0, lo);
    rd(3'd1, hi);
    a = {hi, lo};
  endtask

  initial begin
    logic [7:0]  v;
    logic [15:0] a;
    int          acc0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Reset state
    rd(3'd4, v);
    check(v == 8'h00, "R6 reset status", {24'd0, v}, 32'h0);
    rd_addr(a);
    check(a == 16'h0000, "R9 reset address", {16'd0, a}, 32'h0);
    check({irq, m_valid, s_ready} == 3'b000, "R8 reset outputs", {29'd0, irq, m_valid, s_ready}, 32'h0);

    // R3: byte write of three bytes at 0x10
    prog(16'h0010, 16'd3, 3'b000);
    cfg_wr(3'd4, 8'h02);
    push(16'hF0AA); push(16'h00BB); push(16'h00CC);
    wait_done("R6 done after byte write");
    check({mbyte(16), mbyte(17), mbyte(18)} == 24'hAABBCC, "R3 bytes in memory",
          {8'd0, mbyte(16), mbyte(17), mbyte(18)}, 32'h00AABBCC);
    rd_addr(a);
    check(a == 16'h0013, "R9 current address after write", {16'd0, a}, 32'h13);
    cfg_wr(3'd6, 8'h01);
    rd(3'd4, v);
    check(v == 8'h00, "R7 clear of done", {24'd0, v}, 32'h0);

    // R3: byte read back
    exp_q.push_back(16'h00AA); exp_q.push_back(16'h00BB); exp_q.push_back(16'h00CC);
    prog(16'h0010, 16'd3, 3'b000);
    cfg_wr(3'd4, 8'h01);
    wait_done("R6 done after byte read");
    check(exp_q.size() == 0, "R3 all read beats delivered", exp_q.size(), 32'd0);
    cfg_wr(3'd6, 8'h01);

    // R4/R5: word write, little order, odd count 5 at 0x20
    prog(16'h0020, 16'd5, 3'b001);
    cfg_wr(3'd4, 8'h02);
    push(16'h2211); push(16'h4433); push(16'hEE55);
    wait_done("R4 done after word write");
    check({mbyte(32), mbyte(33), mbyte(34), mbyte(35)} == 32'h11223344, "R5 little order bytes",
          {mbyte(32), mbyte(33), mbyte(34), mbyte(35)}, 32'h11223344);
    check({mbyte(36), mbyte(37)} == 16'h5500, "R4 final single byte",
          {16'd0, mbyte(36), mbyte(37)}, 32'h5500);
    rd_addr(a);
    check(a == 16'h0025, "R4 address after odd word count", {16'd0, a}, 32'h25);

    // R8: interrupt follows enable
    check(irq == 1'b0, "R8 irq off without enable", {31'd0, irq}, 32'd0);
    cfg_wr(3'd5, 8'h05);
    @(negedge clk);
    check(irq == 1'b1, "R8 irq with enable", {31'd0, irq}, 32'd1);
    cfg_wr(3'd6, 8'h01);
    @(negedge clk);
    check(irq == 1'b0, "R8 irq drops with done", {31'd0, irq}, 32'd0);

    // R5: word read, big order, with back-pressure
    bp_toggle = 1'b1;
    exp_q.push_back(16'h1122); exp_q.push_back(16'h3344);
    prog(16'h0020, 16'd4, 3'b011);
    cfg_wr(3'd4, 8'h01);
    wait_done("R5 done after word read");
    check(exp_q.size() == 0, "R5 big order beats delivered", exp_q.size(), 32'd0);
    bp_toggle = 1'b0;
    cfg_wr(3'd6, 8'h01);

    // R2: abort with a beat waiting for the host
    bp_hold = 1'b1;
    prog(16'h0030, 16'd8, 3'b000);
    cfg_wr(3'd4, 8'h01);
    for (int i = 0; i < 20 && !m_valid; i++) @(negedge clk);
    check(m_valid == 1'b1, "R10 beat waits under back-pressure", {31'd0, m_valid}, 32'd1);
    cfg_wr(3'd4, 8'h04);
    rd(3'd4, v);
    check(v == 8'h00, "R2 abort clears busy without done", {24'd0, v}, 32'h0);
    check(m_valid == 1'b0, "R2 abort drops pending beat", {31'd0, m_valid}, 32'd0);
    rd_addr(a);
    check(a == 16'h0031, "R2 address kept where stopped", {16'd0, a}, 32'h31);
    rd(3'd2, v);
    check(v == 8'd7, "R10 remaining count after abort", {24'd0, v}, 32'd7);
    bp_hold = 1'b0;
    cfg_wr(3'd2, 8'h00);

    // R1: illegal and out-of-scope codes ignored
    cfg_wr(3'd0, 8'h40);
    cfg_wr(3'd4, 8'h00);
    cfg_wr(3'd4, 8'h03);
    rd(3'd4, v);
    check(v == 8'h00, "R1 codes 000/011 do not start", {24'd0, v}, 32'h0);
    rd_addr(a);
    check(a == 16'h0031, "R9 address not reloaded by ignored code", {16'd0, a}, 32'h31);

    // R1/R10: commands and count writes ignored while busy
    prog(16'h0050, 16'd2, 3'b000);
    cfg_wr(3'd4, 8'h02);
    cfg_wr(3'd4, 8'h01);
    cfg_wr(3'd2, 8'h09);
    rd(3'd2, v);
    check(v == 8'd2, "R10 count write ignored while busy", {24'd0, v}, 32'd2);
    check(s_ready == 1'b1, "R1 read command ignored while busy", {31'd0, s_ready}, 32'd1);
    push(16'h005A); push(16'h005B);
    wait_done("R1 write completes after ignored command");
    check({mbyte(80), mbyte(81)} == 16'h5A5B, "R1 write data after ignored command",
          {16'd0, mbyte(80), mbyte(81)}, 32'h5A5B);
    cfg_wr(3'd6, 8'h01);

    // R6/R7: zero count completes on the same edge as a clear
    prog(16'h0060, 16'd0, 3'b000);
    acc0 = mem_acc;
    cfg_wr(3'd4, 8'h02);
    cfg_wr(3'd6, 8'h01);
    rd(3'd4, v);
    check(v == 8'h01, "R7 set wins over clear", {24'd0, v}, 32'h1);
    check(mem_acc == acc0, "R6 zero count makes no access", mem_acc, acc0);
    cfg_wr(3'd6, 8'h01);
    rd(3'd4, v);
    check(v == 8'h00, "R7 later clear drops done", {24'd0, v}, 32'h0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule